// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This unit watches the address of the instruction that is next to complete. It raises a precise breakpoint exception when that address satisfies the condition programmed into two breakpoint comparators. When a hit occurs, three things happen. Completion of the tagged instruction is held off in the same cycle. A single-cycle exception request carrying the fixed vector offset 0x1300 is issued. The full address of the tagged instruction is captured for the save/restore register.

The hold stays in force until the exception handler returns, which the pipeline signals with a return-from-exception pulse. A one-shot suppress flag then lets the same instruction complete once without being trapped again. Both comparators are set up through a register write port that only supervisor mode may use. A shared control register chooses each comparator's compare type and how the two results are combined. Combined modes can express an address range, either inside or outside it.

Top module: `iabp_unit`

## Requirements
- R1: Each breakpoint register has an enable bit at bit 0. A register whose enable bit is 0 never produces a hit, whatever the completing address.
- R2: Comparison uses word addresses only. Bits [1:0] of both the completing address and the breakpoint register are ignored.
- R3: When `cmp_valid` is high with a hit and no exception is pending, `hold_complete` is high in that same cycle. It stays high through the cycle in which `rfe_pulse` is seen and falls in the following cycle.
- R4: `exc_req` is high for exactly one cycle, the cycle after the hit. `exc_vector` always reads 0x1300.
- R5: On a hit, `save_addr` is loaded with the full completing address. The new value is visible from the cycle after the hit and is held until the next hit.
- R6: An `rfe_pulse` while an exception is pending arms a suppress flag. The next `cmp_valid` instruction whose word address equals the saved one is not trapped. The flag clears on the next `cmp_valid`, whatever its address. An `rfe_pulse` with nothing pending has no effect.
- R7: Control bits [1:0] set the compare type of comparator A and bits [3:2] that of comparator B. The codes are 00 equal, 01 completing address less than register, 10 completing address greater than or equal to register, and 11 equal.
- R8: Control bits [5:4] set how the two comparators combine. 00 and 11 mean either enabled comparator hits. 01 (inside) hits when both are enabled and both hit. 10 (outside) hits when both are enabled and not both hit.
- R9: When both comparators hit in the same cycle, the unit raises exactly one exception request and performs one address capture.
- R10: While an exception is pending, completing instructions raise no new exception request and do not change `save_addr`.
- R11: Register writes take effect on the next cycle. `reg_sel` 0 selects comparator A, 1 comparator B, 2 control, and 3 nothing. A write with `reg_super` low changes no register and pulses `priv_err` high in the next cycle.
- R12: After reset, both breakpoint registers and the control register are zero. All outputs other than `exc_vector` are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | An instruction is next to complete this cycle |
| cmp_addr | input | ADDR_W | Address of the instruction next to complete |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 comparator A, 1 comparator B, 2 control |
| reg_wdata | input | ADDR_W | Register write data |
| reg_super | input | 1 | Writer is in supervisor mode |
| rfe_pulse | input | 1 | Return from the breakpoint exception |
| hold_complete | output | 1 | Block completion of the current instruction |
| exc_req | output | 1 | Exception request pulse |
| exc_vector | output | ADDR_W | Exception vector offset, 0x1300 |
| save_addr | output | ADDR_W | Address of the trapped instruction for the save/restore register |
| priv_err | output | 1 | A write from non-supervisor mode was refused |

## Verification
The embedded assertions check a set of properties on every cycle:

- a request always coincides with a held completion;
- every request is a single-cycle pulse;
- the captured address equals the address that completed one cycle earlier;
- no request follows a pending cycle;
- the suppress flag lives for exactly one completing instruction;
- user-mode writes leave all registers unchanged;
- with both comparators disabled, a completing instruction is never held off.

The outcome of each compare type and combine mode, and the masking of only the re-issued instruction, depend on programmed values. Those are shown only by the bench's scenarios, which compare every output with a behavioural model on every cycle.

// File: rtl/iabp_pkg.sv
package iabp_pkg;

  localparam int CTRL_W = 6;
  localparam int MAXW   = 64;

  typedef enum logic [1:0] {
    CMP_EQ     = 2'b00,
    CMP_LT     = 2'b01,
    CMP_GE     = 2'b10,
    CMP_EQ_ALT = 2'b11
  } cmp_kind_e;

  typedef enum logic [1:0] {
    CMB_EITHER     = 2'b00,
    CMB_INSIDE     = 2'b01,
    CMB_OUTSIDE    = 2'b10,
    CMB_EITHER_ALT = 2'b11
  } combine_e;

  // Word-address relation between the completing address and a register (R2, R7)
  function automatic logic kind_hit(input cmp_kind_e kind,
                                    input logic [MAXW-1:0] word_addr,
                                    input logic [MAXW-1:0] word_ref);
    case (kind)
      CMP_LT:  return word_addr <  word_ref;
      CMP_GE:  return word_addr >= word_ref;
      default: return word_addr == word_ref;
    endcase
  endfunction

  // Combination of two comparator results (R1, R8)
  function automatic logic combine_hit(input combine_e mode,
                                       input logic en_a, input logic raw_a,
                                       input logic en_b, input logic raw_b);
    case (mode)
      CMB_INSIDE:  return en_a && en_b && raw_a && raw_b;
      CMB_OUTSIDE: return en_a && en_b && !(raw_a && raw_b);
      default:     return (en_a && raw_a) || (en_b && raw_b);
    endcase
  endfunction

endpackage

// File: rtl/iabp_regs.sv
module iabp_regs
  import iabp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [1:0]                  reg_sel,
  input  logic [ADDR_W-1:0]           reg_wdata,
  input  logic                        reg_super,
  output logic [1:0][ADDR_W-1:0]      bp_regs,
  output logic [CTRL_W-1:0]           ctrl,
  output logic                        priv_err
);

  logic [1:0][ADDR_W-1:0] bp_q;
  logic [CTRL_W-1:0]      ctrl_q;
  logic                   priv_q;
  logic                   wr_ok;
  logic                   wr_refused;

  assign wr_ok      = reg_we && reg_super;
  assign wr_refused = reg_we && !reg_super;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_q   <= '0;
      ctrl_q <= '0;
      priv_q <= 1'b0;
    end else begin
      priv_q <= wr_refused;
      if (wr_ok) begin
        case (reg_sel)
          2'd0:    bp_q[0] <= reg_wdata;
          2'd1:    bp_q[1] <= reg_wdata;
          2'd2:    ctrl_q  <= reg_wdata[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign bp_regs  = bp_q;
  assign ctrl     = ctrl_q;
  assign priv_err = priv_q;

  p_user_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refused |=> priv_q && $stable(bp_q) && $stable(ctrl_q));

endmodule

// File: rtl/iabp_cmp.sv
module iabp_cmp
  import iabp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [ADDR_W-1:0] bp_reg,
  input  cmp_kind_e         kind,
  output logic              enabled,
  output logic              raw_hit
);

  localparam int WORD_W = ADDR_W - 2;

  logic [MAXW-1:0] word_addr;
  logic [MAXW-1:0] word_ref;

  assign word_addr = MAXW'(cmp_addr[ADDR_W-1:2]);
  assign word_ref  = MAXW'(bp_reg[ADDR_W-1:2]);
  assign enabled   = bp_reg[0];
  assign raw_hit   = kind_hit(kind, word_addr, word_ref);

  initial begin
    assert (WORD_W > 0 && ADDR_W <= MAXW);
  end

endmodule

// File: rtl/iabp_ctrl.sv
module iabp_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              bp_hit,
  input  logic              rfe_pulse,
  output logic              hold_complete,
  output logic              exc_req,
  output logic [ADDR_W-1:0] save_addr,
  output logic              pending,
  output logic              suppress
);

  logic              pending_q;
  logic              supp_q;
  logic              exc_q;
  logic [ADDR_W-1:0] save_q;
  logic              supp_masks;
  logic              match_now;
  logic              return_now;

  assign supp_masks = supp_q && (cmp_addr[ADDR_W-1:2] == save_q[ADDR_W-1:2]);
  assign match_now  = cmp_valid && bp_hit && !pending_q && !supp_masks;
  assign return_now = pending_q && rfe_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      supp_q    <= 1'b0;
      exc_q     <= 1'b0;
      save_q    <= '0;
    end else begin
      exc_q <= match_now;
      if (match_now) save_q <= cmp_addr;
      if (match_now)       pending_q <= 1'b1;
      else if (return_now) pending_q <= 1'b0;
      if (return_now)      supp_q <= 1'b1;
      else if (cmp_valid)  supp_q <= 1'b0;
    end
  end

  assign hold_complete = pending_q || match_now;
  assign exc_req       = exc_q;
  assign save_addr     = save_q;
  assign pending       = pending_q;
  assign suppress      = supp_q;

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> hold_complete);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |=> !exc_q);

  p_save_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> save_q == $past(cmp_addr));

  p_no_req_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> !exc_q);

  p_suppress_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (supp_q && cmp_valid && !return_now) |=> !supp_q);

endmodule

// File: rtl/iabp_unit.sv
module iabp_unit
  import iabp_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_1300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              reg_super,
  input  logic              rfe_pulse,
  output logic              hold_complete,
  output logic              exc_req,
  output logic [ADDR_W-1:0] exc_vector,
  output logic [ADDR_W-1:0] save_addr,
  output logic              priv_err
);

  localparam int NCMP = 2;

  logic [NCMP-1:0][ADDR_W-1:0] bp_regs;
  logic [CTRL_W-1:0]           ctrl;
  logic [NCMP-1:0]             cmp_en;
  logic [NCMP-1:0]             cmp_raw;
  logic                        bp_hit;
  logic                        pending;
  logic                        suppress;

  iabp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_super (reg_super),
    .bp_regs   (bp_regs),
    .ctrl      (ctrl),
    .priv_err  (priv_err)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    iabp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .cmp_addr (cmp_addr),
      .bp_reg   (bp_regs[g]),
      .kind     (cmp_kind_e'(ctrl[2*g +: 2])),
      .enabled  (cmp_en[g]),
      .raw_hit  (cmp_raw[g])
    );
  end

  assign bp_hit = combine_hit(combine_e'(ctrl[5:4]),
                              cmp_en[0], cmp_raw[0], cmp_en[1], cmp_raw[1]);

  iabp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_valid     (cmp_valid),
    .cmp_addr      (cmp_addr),
    .bp_hit        (bp_hit),
    .rfe_pulse     (rfe_pulse),
    .hold_complete (hold_complete),
    .exc_req       (exc_req),
    .save_addr     (save_addr),
    .pending       (pending),
    .suppress      (suppress)
  );

  assign exc_vector = ADDR_W'(VEC_OFFSET);

  p_disabled_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !pending && !bp_regs[0][0] && !bp_regs[1][0]) |-> !hold_complete);

endmodule

// File: tb/tb_iabp_unit.sv
`timescale 1ns/1ps
module tb_iabp_unit;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [AW-1:0] cmp_addr = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          reg_super = 1'b0;
  logic          rfe_pulse = 1'b0;
  logic          hold_complete, exc_req, priv_err;
  logic [AW-1:0] exc_vector, save_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iabp_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_super(reg_super), .rfe_pulse(rfe_pulse),
    .hold_complete(hold_complete), .exc_req(exc_req), .exc_vector(exc_vector),
    .save_addr(save_addr), .priv_err(priv_err)
  );

  // behavioural reference state
  logic [AW-1:0] m_reg[2];
  logic [AW-1:0] m_ctrl, m_save, m_supp_addr;
  bit m_pend, m_supp, m_exc, m_priv;

  function automatic bit relation(int kind, longint unsigned a, longint unsigned r);
    if (kind == 1) return a < r;
    if (kind == 2) return a >= r;
    return a == r;
  endfunction

  function automatic bit model_hit(logic [AW-1:0] addr);
    bit h[2];
    bit e[2];
    int mode;
    for (int i = 0; i < 2; i++) begin
      e[i] = m_reg[i][0];
      h[i] = relation(int'((m_ctrl >> (2*i)) & 3), longint'(addr / 4), longint'(m_reg[i] / 4));
    end
    mode = int'((m_ctrl >> 4) & 3);
    if (mode == 1) return e[0] && e[1] && h[0] && h[1];
    if (mode == 2) return e[0] && e[1] && !(h[0] && h[1]);
    return (e[0] && h[0]) || (e[1] && h[1]);
  endfunction

  task automatic check(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [AW-1:0] a, bit we, logic [1:0] sel,
                     logic [AW-1:0] wd, bit sup, bit rfe, string tag);
    bit match;
    cmp_valid = v; cmp_addr = a; reg_we = we; reg_sel = sel;
    reg_wdata = wd; reg_super = sup; rfe_pulse = rfe;
    match = v && !m_pend && !(m_supp && (a / 4 == m_supp_addr / 4)) && model_hit(a);
    @(negedge clk);
    check(tag, "hold_complete", AW'(hold_complete), AW'(m_pend || match));
    check(tag, "exc_req", AW'(exc_req), AW'(m_exc));
    check(tag, "save_addr", save_addr, m_save);
    check(tag, "priv_err", AW'(priv_err), AW'(m_priv));
    check("R4", "exc_vector", exc_vector, 32'h1300);
    @(posedge clk);
    m_exc = match;
    m_priv = we && !sup;
    if (we && sup) begin
      if (sel == 0) m_reg[0] = wd;
      else if (sel == 1) m_reg[1] = wd;
      else if (sel == 2) m_ctrl = wd & 32'h3f;
    end
    if (match) m_save = a;
    if (m_pend && rfe) begin
      m_pend = 0; m_supp = 1; m_supp_addr = m_save;
    end else begin
      if (v) m_supp = 0;
      if (match) m_pend = 1;
    end
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [AW-1:0] wd, string tag);
    cyc(0, '0, 1, sel, wd, 1, 0, tag);
  endtask

  task automatic comp(logic [AW-1:0] a, string tag);
    cyc(1, a, 0, 0, '0, 1, 0, tag);
  endtask

  task automatic idle(string tag);
    cyc(0, '0, 0, 0, '0, 1, 0, tag);
  endtask

  task automatic ret(string tag);
    cyc(0, '0, 0, 0, '0, 1, 1, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_reg[0] = '0; m_reg[1] = '0; m_ctrl = '0; m_save = '0; m_supp_addr = '0;
    m_pend = 0; m_supp = 0; m_exc = 0; m_priv = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R12 reset state");

    // R11: user-mode write refused, register stays disabled
    cyc(0, '0, 1, 0, 32'h101, 0, 0, "R11 user write");
    idle("R11 priv_err pulse");
    comp(32'h100, "R11 write ignored");
    cyc(0, '0, 1, 3, 32'h101, 1, 0, "R11 select 3");
    comp(32'h100, "R11 select 3 ignored");

    // R1: register loaded but not enabled
    wr(0, 32'h100, "R1 disabled write");
    comp(32'h100, "R1 disabled no hit");

    // R2/R3/R5/R10/R6
    wr(0, 32'h101, "R1 enable");
    comp(32'h103, "R2 low bits ignored");
    idle("R4 request pulse");
    comp(32'h100, "R10 pending ignores completion");
    idle("R3 still held");
    ret("R3 return");
    comp(32'h103, "R6 suppressed retire");
    comp(32'h100, "R6 one-shot then hit");
    ret("R6 return");
    comp(32'h200, "R6 other address clears flag");
    comp(32'h100, "R6 cleared flag re-arms");
    ret("R6 return");
    ret("R6 return while idle");
    comp(32'h100, "R6 masked once");
    comp(32'h100, "R6 idle rfe no effect");
    ret("R6 return");
    comp(32'h300, "R6 flag cleared");

    // R7 compare types
    wr(2, 32'h1, "R7 A less-than");
    comp(32'h0FC, "R7 lt hit");
    ret("R7 return");
    comp(32'h104, "R7 lt miss");
    comp(32'h100, "R7 lt equal miss");
    wr(2, 32'h2, "R7 A ge");
    comp(32'h180, "R7 ge hit");
    ret("R7 return");
    comp(32'h0F0, "R7 ge miss");
    wr(2, 32'h3, "R7 code 11 equal");
    comp(32'h104, "R7 code 11 miss");
    comp(32'h100, "R7 code 11 hit");
    ret("R7 return");

    // R8 combine modes
    wr(1, 32'h200, "R8 B disabled");
    wr(2, 32'h16, "R8 inside");
    comp(32'h180, "R8 inside needs both enabled");
    wr(1, 32'h201, "R8 B enable");
    comp(32'h180, "R8 inside hit");
    ret("R8 return");
    comp(32'h300, "R8 inside miss high");
    comp(32'h080, "R8 inside miss low");
    wr(2, 32'h26, "R8 outside");
    comp(32'h180, "R8 outside miss");
    comp(32'h300, "R8 outside hit high");
    ret("R8 return");
    comp(32'h040, "R8 outside hit low");
    ret("R8 return");
    wr(2, 32'h32, "R8 code 11 either");
    comp(32'h1FC, "R8 code 11 hit");
    ret("R8 return");

    // R9 both comparators hit together
    wr(2, 32'h0, "R9 equal both");
    wr(1, 32'h101, "R9 B same address");
    comp(32'h100, "R9 dual hit");
    idle("R9 single request");
    idle("R9 no second request");
    ret("R9 return");
    idle("R9 released");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule